// File: doc/BRIEF.md
# 64-Source Interrupt Controller

This block gathers 64 interrupt inputs and folds them into one registered interrupt request for a processor. Software reaches it through a small word-addressed register port. The port offers a controller-wide enable, two 32-bit enable words indexed by source, two read-only pending words indexed by channel, and sixteen routing words. Each routing word holds four byte-wide slots. Each slot names the source that drives one pending channel.

A build-time parameter selects how inputs are read. In level mode a source counts as active while its input is high. In pulse mode, any cycle with the input high sets a sticky flag. The flag stays set until software writes a zero to its bit. The flag words are placed eight bytes below the matching enable words. To reach sources 64 to 127, place a second instance 0x100 bytes above the first and scan it the same way.

The request output comes from a two-state machine. It moves from `IRQ_QUIET` to `IRQ_RAISED` when the global enable is set and at least one pending channel is asserted. It moves from `IRQ_RAISED` back to `IRQ_QUIET` when either condition is no longer true. The output is high only in `IRQ_RAISED`.

Top module: `intc64`

## Requirements
- R1: After reset the control word, both enable words, both flag words and both pending words read 0, and `irq_o` is low. Every routing slot selects its own channel number, so routing word 0 reads 0x03020100 and routing word 15 reads 0x3F3E3D3C.
- R2: The enable words are read/write. Word index 4 (byte 0x10) holds sources 31..0 and word index 10 (byte 0x28) holds sources 63..32. A bit at 1 enables the source with that number.
- R3: Bit 31 of the control word (word index 0) is the global enable. While it is 0, `irq_o` stays low whatever is pending.
- R4: `irq_o` is a register equal to (global enable AND the OR of all pending channels), taken at the previous clock edge. In level mode it rises at the first edge after an enabled source goes high.
- R5: The pending words are read-only. Word index 5 (byte 0x14) holds channels 31..0 and word index 11 (byte 0x2C) holds channels 63..32. Channel c is set when the source named by routing slot c is both enabled and active.
- R6: In level mode a source is active exactly while its input is high, and its pending bit clears once the input falls.
- R7: In pulse mode a source input that is high for a single cycle sets flag bit s. The flag bit then keeps the source active after the input falls. Flags for sources 31..0 are at word index 2 (byte 0x08) and flags for sources 63..32 are at word index 8 (byte 0x20).
- R8: Writing a flag word clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R9: If a source input is high in the same cycle that software clears its flag, the flag stays set.
- R10: The routing words are at word indices 16..31 (bytes 0x40..0x7C). Byte k of routing word w controls channel 4w+k. Only the low 6 bits of each byte are stored; the top two bits are ignored and read back as 0.
- R11: Read data appears on `rdata_o` one cycle after the request. Unused word indices read 0. Writes to unused or read-only words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source inputs |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear landing in exactly the same cycle as a new pulse on that source. The stimulus raises the source input and issues the zero-write to the flag word at the same falling edge, so that one rising edge sees both. A readback then shows whether the new event survived. A second difficult case is routing with a non-identity slot that carries junk in its upper bits. This is set up by writing one routing byte, then reading the pending word to see two channels fed by the same source.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned GEN_BIT = 31;

    // Word indices (byte offset / 4) of the fixed registers
    localparam logic [4:0] A_CTRL    = 5'd0;
    localparam logic [4:0] A_FLAG_LO = 5'd2;
    localparam logic [4:0] A_EN_LO   = 5'd4;
    localparam logic [4:0] A_PEND_LO = 5'd5;
    localparam logic [4:0] A_FLAG_HI = 5'd8;
    localparam logic [4:0] A_EN_HI   = 5'd10;
    localparam logic [4:0] A_PEND_HI = 5'd11;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/intc64_regs.sv
module intc64_regs
    import intc64_pkg::*;
#(
    parameter  int unsigned N_SRC     = 64,
    parameter  int unsigned ADDR_W    = 5,
    localparam int unsigned IDX_W     = $clog2(N_SRC),
    localparam int unsigned MAP_WORDS = N_SRC / 4,
    localparam int unsigned MW_W      = $clog2(MAP_WORDS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_i,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [WORD_W-1:0]               wdata_i,
    input  logic [N_SRC-1:0]                flags_i,
    input  logic [N_SRC-1:0]                pend_i,
    output logic                            gen_en_o,
    output logic [N_SRC-1:0]                en_o,
    output logic [N_SRC-1:0][IDX_W-1:0]     map_o,
    output logic                            flag_wr_lo_o,
    output logic                            flag_wr_hi_o,
    output logic [WORD_W-1:0]               rdata_o
);
    logic                        gen_q;
    logic [N_SRC-1:0]            en_q;
    logic [N_SRC-1:0][IDX_W-1:0] map_q;
    logic [WORD_W-1:0]           rdata_q, rd_d;
    logic                        is_map, wr;
    logic [MW_W-1:0]             mw;

    assign is_map = addr_i[ADDR_W-1];
    assign mw     = addr_i[MW_W-1:0];
    assign wr     = req_i && we_i;

    assign flag_wr_lo_o = wr && (addr_i == A_FLAG_LO);
    assign flag_wr_hi_o = wr && (addr_i == A_FLAG_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= 1'b0;
            en_q  <= '0;
            for (int c = 0; c < N_SRC; c++) map_q[c] <= IDX_W'(c);
        end else if (wr) begin
            if (is_map) begin
                for (int k = 0; k < 4; k++)
                    map_q[{mw, 2'(k)}] <= wdata_i[8*k +: IDX_W];
            end else begin
                case (addr_i)
                    A_CTRL:  gen_q <= wdata_i[GEN_BIT];
                    A_EN_LO: en_q[WORD_W-1:0] <= wdata_i;
                    A_EN_HI: en_q[2*WORD_W-1:WORD_W] <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_d = '0;
        if (is_map) begin
            for (int k = 0; k < 4; k++)
                rd_d[8*k +: IDX_W] = map_q[{mw, 2'(k)}];
        end else begin
            case (addr_i)
                A_CTRL:    rd_d[GEN_BIT] = gen_q;
                A_FLAG_LO: rd_d = flags_i[WORD_W-1:0];
                A_FLAG_HI: rd_d = flags_i[2*WORD_W-1:WORD_W];
                A_EN_LO:   rd_d = en_q[WORD_W-1:0];
                A_EN_HI:   rd_d = en_q[2*WORD_W-1:WORD_W];
                A_PEND_LO: rd_d = pend_i[WORD_W-1:0];
                A_PEND_HI: rd_d = pend_i[2*WORD_W-1:WORD_W];
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (req_i && !we_i)   rdata_q <= rd_d;
    end

    assign gen_en_o = gen_q;
    assign en_o     = en_q;
    assign map_o    = map_q;
    assign rdata_o  = rdata_q;

    // R2: enable word takes the written value
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i == A_EN_LO) |=> (en_o[WORD_W-1:0] == $past(wdata_i)));

    // R11: pending read returns the value present at the request edge
    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == A_PEND_LO) |=> (rdata_o == $past(pend_i[WORD_W-1:0])));
endmodule

// File: rtl/intc64_flags.sv
module intc64_flags
    import intc64_pkg::*;
#(
    parameter int unsigned N_SRC      = 64,
    parameter bit          PULSE_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [N_SRC-1:0]   flags_o,
    output logic [N_SRC-1:0]   active_o
);
    if (PULSE_MODE) begin : g_pulse
        logic [N_SRC-1:0] flag_q, flag_d;

        always_comb begin
            flag_d = flag_q;
            if (wr_lo_i) flag_d[WORD_W-1:0]        = flag_q[WORD_W-1:0] & wdata_i;
            if (wr_hi_i) flag_d[2*WORD_W-1:WORD_W] = flag_q[2*WORD_W-1:WORD_W] & wdata_i;
            flag_d = flag_d | src_i;   // a new event wins over a clear
        end

        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= '0;
            else        flag_q <= flag_d;
        end

        assign flags_o  = flag_q;
        assign active_o = flag_q;

        // R7, R9: any high input is held in its flag at the next edge
        a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (|src_i) |=> ((flags_o & $past(src_i)) == $past(src_i)));

        // R7: a flag only turns on when its input was high
        a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            ((flags_o & ~$past(flags_o) & ~$past(src_i)) == '0));

        // R8: bits written as 1 keep their value
        a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo_i |=> ((flags_o[WORD_W-1:0] & $past(wdata_i & flags_o[WORD_W-1:0]))
                         == $past(wdata_i & flags_o[WORD_W-1:0])));
    end else begin : g_level
        logic unused_flag_inputs;
        assign unused_flag_inputs = ^{clk, rst_n, wr_lo_i, wr_hi_i, wdata_i};
        assign flags_o  = '0;
        assign active_o = src_i;
    end
endmodule

// File: rtl/intc64_route.sv
module intc64_route #(
    parameter  int unsigned N_SRC = 64,
    localparam int unsigned IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]            en_i,
    input  logic [N_SRC-1:0]            active_i,
    input  logic [N_SRC-1:0][IDX_W-1:0] map_i,
    output logic [N_SRC-1:0]            pend_o
);
    for (genvar c = 0; c < N_SRC; c++) begin : g_chan
        assign pend_o[c] = en_i[map_i[c]] & active_i[map_i[c]];
    end
endmodule

// File: rtl/intc64.sv
module intc64
    import intc64_pkg::*;
#(
    parameter  int unsigned N_SRC      = 64,
    parameter  int unsigned ADDR_W     = 5,
    parameter  bit          PULSE_MODE = 1'b1,
    localparam int unsigned IDX_W      = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        src_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [4:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    logic                        gen_en, flag_wr_lo, flag_wr_hi, raise;
    logic [N_SRC-1:0]            en, flags, active, pend;
    logic [N_SRC-1:0][IDX_W-1:0] map;
    irq_state_e                  state_q, state_d;

    intc64_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .flags_i(flags), .pend_i(pend), .gen_en_o(gen_en),
        .en_o(en), .map_o(map), .flag_wr_lo_o(flag_wr_lo), .flag_wr_hi_o(flag_wr_hi),
        .rdata_o(rdata_o)
    );

    intc64_flags #(.N_SRC(N_SRC), .PULSE_MODE(PULSE_MODE)) u_flags (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_lo_i(flag_wr_lo),
        .wr_hi_i(flag_wr_hi), .wdata_i(wdata_i), .flags_o(flags), .active_o(active)
    );

    intc64_route #(.N_SRC(N_SRC)) u_route (
        .en_i(en), .active_i(active), .map_i(map), .pend_o(pend)
    );

    assign raise = gen_en && (|pend);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!raise) state_d = IRQ_QUIET;
        endcase
    end

    always_comb irq_o = (state_q == IRQ_RAISED);

    // R3: no request follows a cycle with the global enable off
    a_r3_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !irq_o);

    // R4: a rising request needs an enabled pending channel one edge earlier
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(gen_en && (|pend)));
endmodule

// File: tb/intc64_tb.sv
`timescale 1ns/1ps
module intc64_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_p, rd_l;
    logic        irq_p, irq_l;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    intc64 #(.PULSE_MODE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_p), .irq_o(irq_p));

    intc64 #(.PULSE_MODE(1'b0)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_l), .irq_o(irq_l));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] vp, output logic [31:0] vl);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); vp = rd_p; vl = rd_l; req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] p, l;
        chk("R1 irq pulse", 32'(irq_p), 0);
        chk("R1 irq level", 32'(irq_l), 0);
        rd(5'd0, p, l);  chk("R1 ctrl", p, 0);
        rd(5'd4, p, l);  chk("R1 en lo", p, 0);
        rd(5'd2, p, l);  chk("R1 flag lo", p, 0);
        rd(5'd11, p, l); chk("R1 pend hi", l, 0);
        rd(5'd16, p, l); chk("R1 R10 map word0", p, 32'h03020100);
        rd(5'd31, p, l); chk("R1 R10 map word15", l, 32'h3F3E3D3C);
    endtask

    task automatic t_enable_rw;
        logic [31:0] p, l;
        wr(5'd4, 32'hA5A5_0001);  rd(5'd4, p, l);  chk("R2 en lo", p, 32'hA5A5_0001);
        wr(5'd10, 32'h0F0F_8000); rd(5'd10, p, l); chk("R2 en hi", l, 32'h0F0F_8000);
        wr(5'd4, 0); wr(5'd10, 0);
    endtask

    task automatic t_level;
        logic [31:0] p, l;
        wr(5'd0, 32'h8000_0000);
        wr(5'd4, 32'h0000_0020);
        @(negedge clk); src[5] = 1'b1; src[6] = 1'b1;
        @(negedge clk); chk("R4 irq one edge after input", 32'(irq_l), 1);
        rd(5'd5, p, l); chk("R5 R6 pend lo level", l, 32'h20);
        @(negedge clk); src = '0;
        rd(5'd5, p, l); chk("R6 pend after fall", l, 0);
        @(negedge clk); chk("R6 irq after fall", 32'(irq_l), 0);
        wr(5'd2, 0);
    endtask

    task automatic t_global;
        logic [31:0] p, l;
        wr(5'd0, 0);
        @(negedge clk); src[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 irq gated", 32'(irq_l), 0);
        rd(5'd5, p, l); chk("R3 pend visible", l, 32'h20);
        @(negedge clk); src = '0;
        wr(5'd2, 0); wr(5'd4, 0);
    endtask

    task automatic t_pulse;
        logic [31:0] p, l;
        wr(5'd0, 32'h8000_0000);
        wr(5'd2, 0); wr(5'd8, 0);
        wr(5'd10, 32'h0000_0100);
        @(negedge clk); src[40] = 1'b1;
        @(negedge clk); src[40] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 irq pulse held", 32'(irq_p), 1);
        chk("R7 irq level none", 32'(irq_l), 0);
        rd(5'd8, p, l);  chk("R7 flag hi", p, 32'h100);
        rd(5'd11, p, l); chk("R7 pend hi", p, 32'h100);
        wr(5'd8, 32'hFFFF_FFFF);
        rd(5'd8, p, l);  chk("R8 write one keeps", p, 32'h100);
        wr(5'd8, 32'hFFFF_FEFF);
        rd(5'd8, p, l);  chk("R8 write zero clears", p, 0);
        repeat (2) @(negedge clk);
        chk("R8 irq drops", 32'(irq_p), 0);
        wr(5'd10, 0);
    endtask

    task automatic t_collide;
        logic [31:0] p, l;
        @(negedge clk); src[3] = 1'b1; req = 1'b1; we = 1'b1; addr = 5'd2; wdata = 0;
        @(negedge clk); src[3] = 1'b0; req = 1'b0; we = 1'b0;
        rd(5'd2, p, l); chk("R9 flag survives clear", p, 32'h8);
        wr(5'd2, 0);
        rd(5'd2, p, l); chk("R9 later clear", p, 0);
    endtask

    task automatic t_map;
        logic [31:0] p, l;
        wr(5'd16, 32'h0302_01C9);
        rd(5'd16, p, l); chk("R10 map upper bits dropped", p, 32'h0302_0109);
        wr(5'd4, 32'h0000_0200);
        @(negedge clk); src[9] = 1'b1;
        rd(5'd5, p, l); chk("R10 routed channel", l, 32'h0000_0201);
        @(negedge clk); src = '0;
        wr(5'd16, 32'h0302_0100); wr(5'd4, 0); wr(5'd2, 0);
    endtask

    task automatic t_unused;
        logic [31:0] p, l;
        wr(5'd5, 32'hFFFF_FFFF);
        rd(5'd5, p, l); chk("R11 pend read-only", p, 0);
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, p, l); chk("R11 unused reads zero", p, 0);
        rd(5'd0, p, l); chk("R11 ctrl unaffected", p, 32'h8000_0000);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_level();
        t_global();
        t_pulse();
        t_collide();
        t_map();
        t_unused();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule